// File: doc/BRIEF.md
# Per-Channel Sample Frame Assembler

This block takes a stream of converter samples, each tagged with the channel that produced it, and turns them into wide frames for a stream consumer such as a DMA engine. A frame has sixteen lanes of sixteen bits, with one lane for each channel. The block keeps the last value seen for every channel. A sixteen-bit enable mask tells it which channels take part in the current conversion sequence.

A single mode bit sets when frames go out. In step mode, every accepted sample produces a frame straight away. That frame carries the fresh value in its own lane, and the other lanes hold whatever they last received. In continuous mode, the block collects samples until every enabled channel of one sequence pass has arrived, and then emits one complete frame. In that frame, every lane whose channel is disabled carries the marker 0xDEAD.

The mode bit sits in a small register at one internal address, written and read over a simple configuration port. The output holds each frame under back-pressure. While a frame waits, the sample input stalls.

Top module: `lane_frame_builder`

## Requirements
- R1: After reset the mode bit is 0 (step mode), no frame is valid, the sample input is ready, and every stored lane value is 0.
- R2: A write with `cfg_addr` equal to 0x400 loads the mode register, whose bit 0 is the mode (1 = continuous, 0 = step). `cfg_rdata` returns the register when `cfg_addr` is 0x400 and returns 0 otherwise. Writes to any other address leave the register unchanged.
- R3: A sample word carries the data in bits [19:4] and the channel number in bits [3:0]. Lane n of `frm_data` occupies bits [16n+15:16n].
- R4: In step mode, each accepted sample makes `frm_valid` high in the following cycle. That frame has the sample's data in its channel's lane, and every other lane holds its previously stored value.
- R5: In continuous mode, a frame is emitted only on the sample that completes the set of enabled channels received since the last frame. With an all-zero mask, no frame is ever emitted.
- R6: In a continuous-mode frame, every lane whose mask bit is 0 reads 0xDEAD. Every enabled lane holds its channel's stored value.
- R7: The received-channel record clears whenever a frame is emitted and whenever the mode register is written.
- R8: A channel that arrives again before its pass completes overwrites its stored value. The frame carries the newest value.
- R9: While `frm_valid` is high and `frm_ready` is low, `frm_data` stays stable and `smp_ready` is low.
- R10: In step mode the enable mask has no effect on frame contents or on frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| chan_mask | input | 16 | Channel enable mask, bit n enables channel n |
| smp_valid | input | 1 | Sample word is present |
| smp_ready | output | 1 | Sample word is accepted this cycle when valid |
| smp_word | input | 20 | Data [19:4], channel [3:0] |
| frm_valid | output | 1 | Frame is present |
| frm_ready | input | 1 | Consumer takes the frame |
| frm_data | output | 256 | Sixteen lanes of sixteen bits |

## Verification
The bench goes after the following corner cases, each paired with the fault it would expose:
- **Repeated channel inside one continuous pass.** A design that keeps the older value, or counts samples instead of distinct channels, emits stale data or emits early.
- **Sample on a disabled channel.** A design that lets a disabled sample complete the pass emits too soon. A design that forgets the marker leaks raw data into a disabled lane.
- **All-zero mask.** A design that treats an empty set as complete floods the output with frames.
- **Rewrite of the mode register in the middle of a pass.** A design that keeps old received flags emits a frame one channel too early.
- **Stalled frame with a sample waiting behind it.** A design that fails to stall corrupts the held frame or drops the sample.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int NLANE = 16;
  localparam int LW    = 16;
  localparam int CHW   = $clog2(NLANE);
  localparam int SW    = LW + CHW;
  localparam int FW    = NLANE * LW;
  localparam logic [LW-1:0] MARKER = 16'hDEAD;

  typedef logic [FW-1:0]    frame_t;
  typedef logic [NLANE-1:0] lanes_mask_t;

  // Pass is complete once every enabled channel has been seen; empty mask never completes.
  function automatic logic pass_done(input lanes_mask_t seen, input lanes_mask_t mask);
    return (mask != '0) && ((seen & mask) == mask);
  endfunction

  // Apply the disabled-lane marker in continuous mode; step mode passes raw lanes.
  function automatic frame_t shape_frame(input frame_t raw, input lanes_mask_t mask,
                                         input logic cont);
    frame_t r;
    for (int i = 0; i < NLANE; i++)
      r[i*LW +: LW] = (cont && !mask[i]) ? MARKER : raw[i*LW +: LW];
    return r;
  endfunction
endpackage

// File: rtl/lfb_cfg.sv
module lfb_cfg #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] MODE_ADDR = 12'h400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          mode,
  output logic          wr_hit
);
  logic [DW-1:0] reg_q;

  assign wr_hit = wr_en && (addr == MODE_ADDR);
  assign rdata  = (addr == MODE_ADDR) ? reg_q : '0;
  assign mode   = reg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_q <= '0;
    else if (wr_hit) reg_q <= wdata;
  end
endmodule

// File: rtl/lfb_lanes.sv
module lfb_lanes
  import lfb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CHW-1:0]    chan,
  input  logic [LW-1:0]     data,
  input  logic              cont,
  input  lanes_mask_t       mask,
  input  logic              clr,
  output frame_t            lanes_nx,
  output lanes_mask_t       seen_q,
  output logic              emit
);
  frame_t      lanes_q;
  lanes_mask_t seen_nx;
  lanes_mask_t hit;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign hit[g] = take && (chan == CHW'(g));
    assign lanes_nx[g*LW +: LW] = hit[g] ? data : lanes_q[g*LW +: LW];
  end

  assign seen_nx = seen_q | hit;
  assign emit    = take && (!cont || pass_done(seen_nx, mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lanes_q <= '0;
      seen_q  <= '0;
    end else begin
      lanes_q <= lanes_nx;
      seen_q  <= (clr || emit) ? '0 : seen_nx;
    end
  end
endmodule

// File: rtl/lfb_out.sv
module lfb_out
  import lfb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame_in,
  input  logic   frm_ready,
  output logic   frm_valid,
  output frame_t frm_data,
  output logic   can_take
);
  assign can_take = !frm_valid || frm_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      frm_data  <= '0;
    end else if (load) begin
      frm_valid <= 1'b1;
      frm_data  <= frame_in;
    end else if (frm_ready) begin
      frm_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_frame_builder.sv
module lane_frame_builder
  import lfb_pkg::*;
#(
  parameter int CFG_AW = 12,
  parameter int CFG_DW = 8,
  parameter logic [CFG_AW-1:0] MODE_ADDR = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic [NLANE-1:0]  chan_mask,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SW-1:0]     smp_word,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [FW-1:0]     frm_data
);
  logic        mode_q;
  logic        cfg_hit;
  logic        take;
  logic        emit;
  lanes_mask_t seen_q;
  frame_t      lanes_nx;

  assign take = smp_valid && smp_ready;

  lfb_cfg #(.AW(CFG_AW), .DW(CFG_DW), .MODE_ADDR(MODE_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .mode(mode_q), .wr_hit(cfg_hit)
  );

  lfb_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .take(take),
    .chan(smp_word[CHW-1:0]), .data(smp_word[SW-1:CHW]),
    .cont(mode_q), .mask(chan_mask), .clr(cfg_hit),
    .lanes_nx(lanes_nx), .seen_q(seen_q), .emit(emit)
  );

  lfb_out u_out (
    .clk(clk), .rst_n(rst_n), .load(emit),
    .frame_in(shape_frame(lanes_nx, chan_mask, mode_q)),
    .frm_ready(frm_ready), .frm_valid(frm_valid), .frm_data(frm_data),
    .can_take(smp_ready)
  );
endmodule

// File: rtl/lfb_chk.sv
module lfb_chk
  import lfb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_q,
  input logic              emit,
  input logic [NLANE-1:0]  seen_q,
  input logic [NLANE-1:0]  chan_mask,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [FW-1:0]     frm_data
);
  // R9
  held_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm_data));
  // R9
  input_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |-> !smp_ready);
  // R4
  step_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !mode_q |=> frm_valid);
  // R7
  seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> seen_q == '0);
  // R5
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && chan_mask == '0 |-> !emit);
endmodule

bind lane_frame_builder lfb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .emit(emit), .seen_q(seen_q),
  .chan_mask(chan_mask), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data)
);

// File: tb/sim_lane_frame_builder.sv
module sim_lane_frame_builder;
  localparam int PERIOD = 10;
  localparam int NL = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0;
  logic [11:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [15:0] chan_mask = 16'h0001;
  logic smp_valid = 0, smp_ready;
  logic [19:0] smp_word = 0;
  logic frm_valid, frm_ready = 1;
  logic [255:0] frm_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_lane [NL];
  logic [15:0] m_seen = 0;
  logic m_cont = 0;

  always #(PERIOD/2) clk = ~clk;

  lane_frame_builder u0 (.*);

  function automatic logic [255:0] model_frame(logic [15:0] mask);
    logic [255:0] f;
    for (int i = 0; i < NL; i++) f[i*16 +: 16] = (m_cont && !mask[i]) ? 16'hDEAD : m_lane[i];
    return f;
  endfunction

  function automatic logic model_take(logic [3:0] ch, logic [15:0] d, logic [15:0] mask);
    logic e;
    m_lane[ch] = d;
    m_seen = m_seen | (16'h1 << ch);
    e = !m_cont || (mask != 0 && (m_seen & mask) == mask);
    if (e) m_seen = 0;
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [3:0] ch, logic [15:0] d, string req);
    bit acc, e;
    smp_word = {d, ch};
    smp_valid = 1;
    do begin
      acc = smp_ready;
      @(posedge clk); @(negedge clk);
    end while (!acc);
    smp_valid = 0;
    e = model_take(ch, d, chan_mask);
    chk(frm_valid == e, {req, " frame valid"}, 256'(frm_valid), 256'(e));
    if (e) chk(frm_data == model_frame(chan_mask), {req, " frame data"}, frm_data, model_frame(chan_mask));
  endtask

  task automatic cfg_write(logic [11:0] a, logic [7:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 0;
    if (a == 12'h400) begin m_cont = d[0]; m_seen = 0; end
  endtask

  task automatic cfg_check(logic [7:0] exp, string req);
    cfg_addr = 12'h400; #1;
    chk(cfg_rdata == exp, req, 256'(cfg_rdata), 256'(exp));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < NL; i++) m_lane[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(frm_valid == 0, "R1 valid", 256'(frm_valid), 0);
    chk(smp_ready == 1, "R1 ready", 256'(smp_ready), 1);
    cfg_check(8'h00, "R1 R2 mode reset");
    // R3 R4 directed step sample: only lane 5 nonzero
    send(4'd5, 16'h1234, "R1 R3 R4 first");
    // R4 R10 random step mode with random masks
    for (int k = 0; k < 150; k++) begin
      chan_mask = 16'($urandom);
      send(4'($urandom), 16'($urandom), "R4 R10 step");
    end
    // R2 other address ignored, then mode write
    cfg_write(12'h401, 8'h01);
    cfg_check(8'h00, "R2 other addr");
    cfg_addr = 12'h401; #1;
    chk(cfg_rdata == 0, "R2 other read", 256'(cfg_rdata), 0);
    cfg_write(12'h400, 8'h01);
    cfg_check(8'h01, "R2 mode set");
    // R5 R6 R8 directed continuous pass
    chan_mask = 16'h0005;
    send(4'd0, 16'h1111, "R5 partial");
    send(4'd0, 16'h2222, "R8 repeat");
    send(4'd1, 16'h3333, "R5 R6 disabled chan");
    send(4'd2, 16'h4444, "R6 R8 full pass");
    chk(frm_data[15:0] == 16'h2222, "R8 newest", 256'(frm_data[15:0]), 256'(16'h2222));
    chk(frm_data[31:16] == 16'hDEAD, "R6 marker", 256'(frm_data[31:16]), 256'(16'hDEAD));
    // R5 empty mask never emits
    chan_mask = 16'h0000;
    for (int k = 0; k < 20; k++) send(4'($urandom), 16'($urandom), "R5 empty mask");
    // R7 mode rewrite clears received record
    chan_mask = 16'h0003;
    send(4'd0, 16'h5555, "R7 first");
    cfg_write(12'h400, 8'h01);
    send(4'd1, 16'h6666, "R7 after clear");
    send(4'd0, 16'h7777, "R7 completes");
    // R5 R6 R7 R8 random continuous
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) begin
        chan_mask = 16'($urandom) & 16'($urandom) & 16'($urandom);
        if (chan_mask == 0) chan_mask = 16'h8000;
      end
      send(4'($urandom), 16'($urandom), "R5 R6 R8 cont");
    end
    // R9 back-pressure in step mode
    cfg_write(12'h400, 8'h00);
    frm_ready = 0;
    send(4'd3, 16'hABCD, "R9 load");
    held = frm_data;
    smp_word = {16'hBEEF, 4'd4};
    smp_valid = 1;
    for (int k = 0; k < 3; k++) begin
      chk(smp_ready == 0, "R9 stall", 256'(smp_ready), 0);
      @(posedge clk); @(negedge clk);
      chk(frm_valid && frm_data == held, "R9 hold", frm_data, held);
    end
    frm_ready = 1; #1;
    chk(smp_ready == 1, "R9 release", 256'(smp_ready), 1);
    @(posedge clk); @(negedge clk);
    smp_valid = 0;
    void'(model_take(4'd4, 16'hBEEF, chan_mask));
    chk(frm_valid && frm_data == model_frame(chan_mask), "R9 queued sample",
        frm_data, model_frame(chan_mask));
    @(negedge clk);
    chk(frm_valid == 0, "R9 drained", 256'(frm_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule